// File: doc/BRIEF.md
# Receive Page Segmentation DMA

This block moves one port's received packets into the shared packet memory. It takes 64-bit words from the port's receive FIFO and cuts the packet into 248-byte pieces. Each piece goes into its own page: words 1 to 31 of the page hold the piece, and word 0 holds a link/count header. The header is written only after the page is closed, so it can hold the index of the following page, or an end-of-chain marker on the last page. A packet therefore becomes a linked chain of pages. When the last word has been stored, the block places a transmit command on the shared command bus. The command carries the first page index, the packet length and the destination port mask that address lookup supplied with the last word.

Page indexes come from a small per-port FIFO of free page pointers, which the shared pool refills over a valid/ready pair. If no page can be had partway through a packet, the block gives up on the packet. This happens when the FIFO is empty or when the packet would need more pages than allowed. The block consumes and discards the rest of the packet, hands every page it had taken back on a release port, one per cycle, and issues no command. If the FIFO is empty when a packet starts, the packet is discarded without touching memory.

The controller has six states:
- IDLE: takes the first page when a word is offered. If the FIFO is empty it goes to DRAIN instead.
- DATA: stores words. A last word leads to HDR_END. A page that fills while more data follows leads to HDR_LINK, or to DRAIN when no page can be had.
- HDR_LINK: writes a linking header, then returns to DATA.
- HDR_END: writes the final header and pulses the command, then returns to IDLE.
- DRAIN: discards words up to the packet's last word. It then goes to RELEASE if pages were taken, otherwise to IDLE.
- RELEASE: gives back one page per cycle, then returns to IDLE.

Top module: `rx_page_seg_dma`

## Requirements
- R1: Word i of a page's data piece is written to address {page, i+1} for i = 0..30, and its data is the received word unchanged. A data write happens only in a cycle where a receive word is accepted.
- R2: A page that is followed by another page gets a header at address {page, 0}. Bits [15:0] hold the next page index, bits [31:16] hold 248, and bits [63:32] are zero.
- R3: The last page of a packet gets a header whose bits [15:0] are 16'hFFFF. Its bits [31:16] hold the number of valid bytes in that page (1..248), and bits [63:32] are zero.
- R4: A packet of L bytes writes exactly ceil(L/248) headers. A packet of exactly 248·n bytes uses n pages and takes no trailing page from the free FIFO.
- R5: Pages are used in the order the pool delivered them. The free FIFO accepts a pointer when pool_valid and pool_ready are both high, and pool_ready is low only while the FIFO holds FP_DEPTH pointers.
- R6: cmd_valid is high for exactly one cycle per stored packet, in the cycle of the final header write. In that cycle cmd_first is the first page, cmd_len is the byte count and cmd_mask is rx_dst_mask as given with the last word.
- R7: If the free FIFO is empty when a page is needed mid-packet, the rest of the packet is accepted and discarded, and no command is issued. Every page taken for the packet is then output on rel_ptr with rel_valid, one per cycle in the order taken, and no write or command occurs in those cycles.
- R8: A packet needing more than MAX_PAGES pages is handled as in R7 after MAX_PAGES pages are filled.
- R9: If the free FIFO is empty when a packet's first word is offered, the whole packet is accepted and discarded, with no memory write, no command and no release.
- R10: During and after reset, rx_ready, mem_we, cmd_valid and rel_valid are low and the free FIFO is empty.
- R11: rx_ready is low while idle and in every header-write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive word offered |
| rx_ready | output | 1 | Receive word accepted this cycle when rx_valid is high |
| rx_data | input | 64 | Receive word, byte 0 in bits [7:0] |
| rx_last | input | 1 | Word is the last of the packet |
| rx_nbytes | input | 4 | Valid bytes (1..8) in the last word; other words carry 8 |
| rx_dst_mask | input | PORTS | Destination port mask, valid with the last word |
| pool_valid | input | 1 | Free page pointer offered by the shared pool |
| pool_ptr | input | PTR_W | Offered free page index |
| pool_ready | output | 1 | Free FIFO can take a pointer |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | PTR_W+5 | Write address {page, word} |
| mem_wdata | output | 64 | Write data |
| cmd_valid | output | 1 | Transmit command pulse |
| cmd_first | output | PTR_W | First page of the packet |
| cmd_len | output | LEN_W | Packet length in bytes |
| cmd_mask | output | PORTS | Destination port mask |
| rel_valid | output | 1 | Page being returned to the pool |
| rel_ptr | output | PTR_W | Returned page index |

## Verification
The hardest case to reach from the ports is a page boundary that arrives with the free FIFO dry. The FIFO must hold enough pages for the packet to start, and then run out at exactly the word that fills a page. The bench reaches this by letting the pool fill the FIFO to its depth and then closing the pool. It sends one packet that takes three of the four pages, and then a packet that needs two pages, so the dry FIFO is met at word 31. The next packet, sent while the pool is still closed, then exercises the dry-at-start case. The bench also sweeps lengths around every page multiple, so that the final-page count and the missing trailing page can be computed arithmetically.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int BUS_BYTES = 8;
    localparam logic [15:0] END_MARK = 16'hFFFF;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DATA,
        S_HDR_LINK,
        S_HDR_END,
        S_DRAIN,
        S_RELEASE
    } seg_state_t;

    // header word: [15:0] next page / end marker, [31:16] bytes in page
    function automatic logic [63:0] pack_hdr(input logic [15:0] nxt,
                                             input logic [15:0] cnt);
        return {32'd0, cnt, nxt};
    endfunction
endpackage

// File: rtl/seg_free_fifo.sv
module seg_free_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_ptr,
    output logic         in_ready,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   fill_q;
    logic          push;

    assign in_ready = (fill_q != (AW+1)'(DEPTH));
    assign empty    = (fill_q == '0);
    assign push     = in_valid && in_ready;
    assign head     = slots[rd_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= '0;
            rd_q   <= '0;
            fill_q <= '0;
        end else begin
            if (push) begin
                slots[wr_q] <= in_ptr;
                wr_q        <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
            end
            if (pop && !empty) begin
                rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
            end
            unique case ({push, pop && !empty})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end
endmodule

// File: rtl/seg_page_list.sv
module seg_page_list #(
    parameter int W    = 9,
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  logic [W-1:0]    wptr,
    input  logic [IDXW-1:0] ridx,
    output logic [W-1:0]    rptr
);
    logic [W-1:0] taken [2**IDXW];

    always_ff @(posedge clk) begin
        if (we) taken[widx] <= wptr;
    end

    assign rptr = taken[ridx];
endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl
    import seg_pkg::*;
#(
    parameter int PTR_W         = 9,
    parameter int PG_DATA_BYTES = 248,
    parameter int MAX_PAGES     = 7,
    parameter int PORTS         = 5,
    parameter int LEN_W         = 16,
    parameter int WORD_W        = 5,
    parameter int NP_W          = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    output logic                    rx_ready,
    input  logic [63:0]             rx_data,
    input  logic                    rx_last,
    input  logic [3:0]              rx_nbytes,
    input  logic [PORTS-1:0]        rx_dst_mask,
    input  logic                    fp_empty,
    input  logic [PTR_W-1:0]        fp_head,
    output logic                    fp_pop,
    output logic                    list_we,
    output logic [NP_W-1:0]         list_widx,
    output logic [NP_W-1:0]         list_ridx,
    input  logic [PTR_W-1:0]        list_rptr,
    output logic                    mem_we,
    output logic [PTR_W+WORD_W-1:0] mem_addr,
    output logic [63:0]             mem_wdata,
    output logic                    cmd_valid,
    output logic [PTR_W-1:0]        cmd_first,
    output logic [LEN_W-1:0]        cmd_len,
    output logic [PORTS-1:0]        cmd_mask,
    output logic                    rel_valid,
    output logic [PTR_W-1:0]        rel_ptr
);
    localparam int PG_WORDS = PG_DATA_BYTES / BUS_BYTES;
    localparam int PGC_W    = $clog2(PG_DATA_BYTES + 1);

    seg_state_t       state_q, state_d;
    logic [PTR_W-1:0] cur_q, nxt_q, first_q;
    logic [WORD_W-1:0] widx_q;
    logic [PGC_W-1:0] pg_bytes_q;
    logic [LEN_W-1:0] pkt_bytes_q;
    logic [NP_W-1:0]  npages_q, ridx_q;
    logic [PORTS-1:0] mask_q;

    logic [3:0] nb;
    logic       page_full, need_page, no_page, alloc_first, alloc_next;

    assign nb          = rx_last ? rx_nbytes : 4'd8;
    assign page_full   = (widx_q == WORD_W'(PG_WORDS - 1));
    assign need_page   = (state_q == S_DATA) && rx_valid && !rx_last && page_full;
    assign no_page     = fp_empty || (npages_q == NP_W'(MAX_PAGES));
    assign alloc_first = (state_q == S_IDLE) && rx_valid && !fp_empty;
    assign alloc_next  = need_page && !no_page;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (rx_valid) state_d = fp_empty ? S_DRAIN : S_DATA;
            end
            S_DATA: begin
                if (rx_valid) begin
                    if (rx_last)        state_d = S_HDR_END;
                    else if (page_full) state_d = no_page ? S_DRAIN : S_HDR_LINK;
                end
            end
            S_HDR_LINK: state_d = S_DATA;
            S_HDR_END:  state_d = S_IDLE;
            S_DRAIN: begin
                if (rx_valid && rx_last)
                    state_d = (npages_q != '0) ? S_RELEASE : S_IDLE;
            end
            S_RELEASE: begin
                if (ridx_q == npages_q - 1'b1) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rx_ready  = 1'b0;
        fp_pop    = 1'b0;
        list_we   = 1'b0;
        list_widx = npages_q;
        mem_we    = 1'b0;
        mem_addr  = {cur_q, WORD_W'(0)};
        mem_wdata = rx_data;
        cmd_valid = 1'b0;
        rel_valid = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                fp_pop    = alloc_first;
                list_we   = alloc_first;
                list_widx = '0;
            end
            S_DATA: begin
                rx_ready = 1'b1;
                mem_we   = rx_valid;
                mem_addr = {cur_q, WORD_W'(widx_q + 1'b1)};
                fp_pop   = alloc_next;
                list_we  = alloc_next;
            end
            S_HDR_LINK: begin
                mem_we    = 1'b1;
                mem_wdata = pack_hdr(16'(nxt_q), 16'(pg_bytes_q));
            end
            S_HDR_END: begin
                mem_we    = 1'b1;
                mem_wdata = pack_hdr(END_MARK, 16'(pg_bytes_q));
                cmd_valid = 1'b1;
            end
            S_DRAIN: begin
                rx_ready = 1'b1;
            end
            S_RELEASE: begin
                rel_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign list_ridx = ridx_q;
    assign rel_ptr   = list_rptr;
    assign cmd_first = first_q;
    assign cmd_len   = pkt_bytes_q;
    assign cmd_mask  = mask_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            nxt_q       <= '0;
            first_q     <= '0;
            widx_q      <= '0;
            pg_bytes_q  <= '0;
            pkt_bytes_q <= '0;
            npages_q    <= '0;
            ridx_q      <= '0;
            mask_q      <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (alloc_first) begin
                        cur_q       <= fp_head;
                        first_q     <= fp_head;
                        npages_q    <= NP_W'(1);
                        widx_q      <= '0;
                        pg_bytes_q  <= '0;
                        pkt_bytes_q <= '0;
                    end else if (rx_valid) begin
                        npages_q <= '0;
                    end
                end
                S_DATA: begin
                    if (rx_valid) begin
                        widx_q      <= widx_q + 1'b1;
                        pg_bytes_q  <= pg_bytes_q + PGC_W'(nb);
                        pkt_bytes_q <= pkt_bytes_q + LEN_W'(nb);
                        if (rx_last) mask_q <= rx_dst_mask;
                    end
                    if (alloc_next) begin
                        nxt_q    <= fp_head;
                        npages_q <= npages_q + 1'b1;
                    end
                end
                S_HDR_LINK: begin
                    cur_q      <= nxt_q;
                    widx_q     <= '0;
                    pg_bytes_q <= '0;
                end
                S_DRAIN: begin
                    ridx_q <= '0;
                end
                S_RELEASE: begin
                    ridx_q <= ridx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rx_page_seg_dma.sv
module rx_page_seg_dma #(
    parameter int PTR_W         = 9,
    parameter int PG_DATA_BYTES = 248,
    parameter int MAX_PAGES     = 7,
    parameter int FP_DEPTH      = 4,
    parameter int PORTS         = 5,
    parameter int LEN_W         = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid,
    output logic                   rx_ready,
    input  logic [63:0]            rx_data,
    input  logic                   rx_last,
    input  logic [3:0]             rx_nbytes,
    input  logic [PORTS-1:0]       rx_dst_mask,
    input  logic                   pool_valid,
    input  logic [PTR_W-1:0]       pool_ptr,
    output logic                   pool_ready,
    output logic                   mem_we,
    output logic [PTR_W+5-1:0]     mem_addr,
    output logic [63:0]            mem_wdata,
    output logic                   cmd_valid,
    output logic [PTR_W-1:0]       cmd_first,
    output logic [LEN_W-1:0]       cmd_len,
    output logic [PORTS-1:0]       cmd_mask,
    output logic                   rel_valid,
    output logic [PTR_W-1:0]       rel_ptr
);
    localparam int PG_WORDS = PG_DATA_BYTES / seg_pkg::BUS_BYTES;
    localparam int WORD_W   = $clog2(PG_WORDS + 1);
    localparam int ADDR_W   = PTR_W + WORD_W;
    localparam int NP_W     = $clog2(MAX_PAGES + 1);

    logic             fp_pop, fp_empty;
    logic [PTR_W-1:0] fp_head;
    logic             list_we;
    logic [NP_W-1:0]  list_widx, list_ridx;
    logic [PTR_W-1:0] list_rptr;
    logic [ADDR_W-1:0] addr_int;

    assign mem_addr = addr_int;

    seg_free_fifo #(.W(PTR_W), .DEPTH(FP_DEPTH)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (pool_valid),
        .in_ptr   (pool_ptr),
        .in_ready (pool_ready),
        .pop      (fp_pop),
        .head     (fp_head),
        .empty    (fp_empty)
    );

    seg_page_list #(.W(PTR_W), .IDXW(NP_W)) u_list (
        .clk  (clk),
        .we   (list_we),
        .widx (list_widx),
        .wptr (fp_head),
        .ridx (list_ridx),
        .rptr (list_rptr)
    );

    seg_ctrl #(
        .PTR_W         (PTR_W),
        .PG_DATA_BYTES (PG_DATA_BYTES),
        .MAX_PAGES     (MAX_PAGES),
        .PORTS         (PORTS),
        .LEN_W         (LEN_W),
        .WORD_W        (WORD_W),
        .NP_W          (NP_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_ready    (rx_ready),
        .rx_data     (rx_data),
        .rx_last     (rx_last),
        .rx_nbytes   (rx_nbytes),
        .rx_dst_mask (rx_dst_mask),
        .fp_empty    (fp_empty),
        .fp_head     (fp_head),
        .fp_pop      (fp_pop),
        .list_we     (list_we),
        .list_widx   (list_widx),
        .list_ridx   (list_ridx),
        .list_rptr   (list_rptr),
        .mem_we      (mem_we),
        .mem_addr    (addr_int),
        .mem_wdata   (mem_wdata),
        .cmd_valid   (cmd_valid),
        .cmd_first   (cmd_first),
        .cmd_len     (cmd_len),
        .cmd_mask    (cmd_mask),
        .rel_valid   (rel_valid),
        .rel_ptr     (rel_ptr)
    );
endmodule

// File: rtl/seg_dma_chk.sv
module seg_dma_chk #(
    parameter int ADDR_W        = 14,
    parameter int WORD_W        = 5,
    parameter int PG_DATA_BYTES = 248
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [63:0]       mem_wdata,
    input logic              cmd_valid,
    input logic              rel_valid
);
    logic hdr_wr;
    assign hdr_wr = mem_we && (mem_addr[WORD_W-1:0] == '0);

    p_data_needs_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !hdr_wr) |-> (rx_valid && rx_ready));

    p_hdr_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_wr |-> (mem_wdata[31:16] != 16'd0 && mem_wdata[31:16] <= 16'(PG_DATA_BYTES)
                    && mem_wdata[63:32] == 32'd0));

    p_cmd_final_hdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (hdr_wr && mem_wdata[15:0] == 16'hFFFF));

    p_cmd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_rel_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (!cmd_valid && !mem_we && !rx_ready));

    p_hdr_blocks_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_wr |-> !rx_ready);
endmodule

bind rx_page_seg_dma seg_dma_chk #(
    .ADDR_W        (ADDR_W),
    .WORD_W        (WORD_W),
    .PG_DATA_BYTES (PG_DATA_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .cmd_valid (cmd_valid),
    .rel_valid (rel_valid)
);

// File: tb/sim_rx_page_seg_dma.sv
`timescale 1ns/1ps
module sim_rx_page_seg_dma;
    localparam int PTR_W = 4;
    localparam int MAXP  = 4;
    localparam int NPG   = 16;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        rx_valid = 0, rx_ready, rx_last = 0;
    logic [63:0] rx_data = '0;
    logic [3:0]  rx_nbytes = 4'd8;
    logic [4:0]  rx_dst_mask = '0;
    logic        pool_valid = 0, pool_ready;
    logic [PTR_W-1:0] pool_ptr;
    logic        mem_we;
    logic [8:0]  mem_addr;
    logic [63:0] mem_wdata;
    logic        cmd_valid, rel_valid;
    logic [PTR_W-1:0] cmd_first, rel_ptr;
    logic [15:0] cmd_len;
    logic [4:0]  cmd_mask;

    always #10 clk = ~clk;

    rx_page_seg_dma #(.PTR_W(PTR_W), .PG_DATA_BYTES(248), .MAX_PAGES(MAXP),
                      .FP_DEPTH(4), .PORTS(5), .LEN_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_last(rx_last), .rx_nbytes(rx_nbytes),
        .rx_dst_mask(rx_dst_mask), .pool_valid(pool_valid), .pool_ptr(pool_ptr),
        .pool_ready(pool_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .cmd_valid(cmd_valid), .cmd_first(cmd_first),
        .cmd_len(cmd_len), .cmd_mask(cmd_mask), .rel_valid(rel_valid),
        .rel_ptr(rel_ptr)
    );

    int tests = 0, fails = 0;
    int pool_next = 0, consumed = 0;
    bit pool_take = 0;
    logic [63:0] mem_m [512];
    int wr_cnt = 0, hdr_cnt = 0, cmd_cnt = 0, rel_cnt = 0;
    logic [PTR_W-1:0] rel_log [16];
    logic [PTR_W-1:0] c_first;
    logic [15:0] c_len;
    logic [4:0]  c_mask;

    assign pool_ptr = PTR_W'(pool_next);

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                mem_m[mem_addr] = mem_wdata;
                wr_cnt++;
                if (mem_addr[4:0] == 5'd0) hdr_cnt++;
            end
            if (cmd_valid) begin
                cmd_cnt++;
                c_first = cmd_first; c_len = cmd_len; c_mask = cmd_mask;
            end
            if (rel_valid) begin
                rel_log[rel_cnt % 16] = rel_ptr;
                rel_cnt++;
            end
        end
        pool_take = pool_valid && pool_ready && rst_n;
    end

    always @(posedge clk) begin
        #1;
        if (pool_take) pool_next = pool_next + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [PTR_W-1:0] pg(input int k);
        return PTR_W'((consumed + k) % NPG);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_pkt(input int len, input logic [4:0] m, input int gap,
                            input int pid);
        int nw;
        nw = (len + 7) / 8;
        for (int i = 0; i < nw; i++) begin
            rx_valid    = 1;
            rx_data     = {16'(pid), 16'(len), 32'(i)};
            rx_last     = (i == nw - 1);
            rx_nbytes   = rx_last ? 4'(len - 8 * (nw - 1)) : 4'd8;
            rx_dst_mask = m;
            do @(negedge clk); while (!rx_ready);
            @(posedge clk); #1;
            rx_valid = 0; rx_last = 0;
            if (gap > 0) cyc(gap);
        end
        cyc(8);
    endtask

    task automatic run_ok(input int len, input logic [4:0] m, input int gap,
                          input int pid);
        int n, c0, h0, r0, nw, cnt;
        bit dok;
        logic [63:0] exp, got, bad_a, bad_e;
        n = (len + 247) / 248;
        nw = (len + 7) / 8;
        c0 = cmd_cnt; h0 = hdr_cnt; r0 = rel_cnt;
        send_pkt(len, m, gap, pid);
        chk(cmd_cnt == c0 + 1 && c_first == pg(0) && c_len == 16'(len) && c_mask == m,
            "R6 command", {32'(c_first), c_len, 11'd0, c_mask}, {32'(pg(0)), 16'(len), 11'd0, m});
        chk(hdr_cnt - h0 == n, "R4 page count", 64'(hdr_cnt - h0), 64'(n));
        for (int j = 0; j < n; j++) begin
            cnt = (j < n - 1) ? 248 : len - 248 * (n - 1);
            exp = {32'd0, 16'(cnt), (j < n - 1) ? 16'(pg(j + 1)) : 16'hFFFF};
            got = mem_m[{pg(j), 5'd0}];
            chk(got == exp, (j < n - 1) ? "R2 link header" : "R3 final header", got, exp);
        end
        dok = 1; bad_a = '0; bad_e = '0;
        for (int i = 0; i < nw; i++) begin
            exp = {16'(pid), 16'(len), 32'(i)};
            got = mem_m[{pg(i / 31), 5'((i % 31) + 1)}];
            if (got != exp && dok) begin dok = 0; bad_a = got; bad_e = exp; end
        end
        chk(dok, "R1 data words", bad_a, bad_e);
        chk(rel_cnt == r0 && !rx_ready, "R11 idle, no release", 64'(rel_cnt - r0), 64'd0);
        consumed += n;
    endtask

    initial begin
        int pid;
        int c0, r0, w0;
        cyc(3);
        @(negedge clk);
        chk(!rx_ready && !mem_we && !cmd_valid && !rel_valid && pool_ready, "R10 reset",
            {59'd0, rx_ready, mem_we, cmd_valid, rel_valid, pool_ready}, 64'd1);
        @(posedge clk); #1;
        rst_n = 1; pool_valid = 1;
        cyc(10);
        @(negedge clk);
        chk(!pool_ready && pool_next == 4, "R5 fifo full", 64'(pool_next), 64'd4);
        @(posedge clk); #1;

        pid = 0;
        for (int L = 1; L <= 24; L++) begin run_ok(L, 5'(pid * 7 + 1), pid % 3, pid); pid++; end
        for (int L = 240; L <= 257; L++) begin run_ok(L, 5'(pid * 7 + 1), 0, pid); pid++; end
        for (int L = 492; L <= 500; L++) begin run_ok(L, 5'(pid * 7 + 1), pid % 2, pid); pid++; end
        for (int L = 743; L <= 745; L++) begin run_ok(L, 5'(pid * 7 + 1), 0, pid); pid++; end
        run_ok(992, 5'h15, 0, pid); pid++;

        // R7: fifo runs dry at a page boundary
        cyc(10);
        pool_valid = 0;
        cyc(2);
        run_ok(600, 5'h03, 0, pid); pid++;
        c0 = cmd_cnt; r0 = rel_cnt;
        send_pkt(300, 5'h04, 0, pid); pid++;
        chk(cmd_cnt == c0, "R7 no command", 64'(cmd_cnt - c0), 64'd0);
        chk(rel_cnt == r0 + 1 && rel_log[r0 % 16] == pg(0), "R7 release",
            {32'(rel_cnt - r0), 32'(rel_log[r0 % 16])}, {32'd1, 32'(pg(0))});
        consumed += 1;

        // R9: fifo empty at packet start
        @(negedge clk);
        chk(pool_ready, "R5 fifo drained", 64'(pool_ready), 64'd1);
        @(posedge clk); #1;
        c0 = cmd_cnt; r0 = rel_cnt; w0 = wr_cnt;
        send_pkt(100, 5'h05, 1, pid); pid++;
        chk(wr_cnt == w0 && cmd_cnt == c0 && rel_cnt == r0, "R9 dropped",
            {32'(wr_cnt - w0), 16'(cmd_cnt - c0), 16'(rel_cnt - r0)}, 64'd0);
        pool_valid = 1;
        cyc(10);
        run_ok(20, 5'h06, 0, pid); pid++;

        // R8: packet needs more pages than allowed
        c0 = cmd_cnt; r0 = rel_cnt;
        send_pkt(993, 5'h07, 0, pid); pid++;
        chk(cmd_cnt == c0, "R8 no command", 64'(cmd_cnt - c0), 64'd0);
        chk(rel_cnt == r0 + MAXP, "R8 release count", 64'(rel_cnt - r0), 64'(MAXP));
        for (int k = 0; k < MAXP; k++)
            chk(rel_log[(r0 + k) % 16] == pg(k), "R8 release order",
                64'(rel_log[(r0 + k) % 16]), 64'(pg(k)));
        consumed += MAXP;
        run_ok(248, 5'h1F, 0, pid); pid++;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule